// File: doc/BRIEF.md
# Remote Terminal Command Latch and Word Counter

This block sits between the protocol core of a serial-bus remote terminal and the host system. Each time the core presents a newly decoded command word, the block captures the command fields and holds them as steady outputs: a broadcast flag, a direction flag, the subaddress and a five-bit field. In a data message that field shows a running word index. In a mode-code message it shows the mode code.

For receive messages there are two delivery modes. In direct mode each data word from the core goes out on the host data bus at once, with a one-cycle strobe. In burst mode the words are stored in an internal FIFO, and the message-end pulse starts a paced drain to the host at a fixed number of clocks per word. For transmit messages the block samples the host bus when the core asks for a word and hands that word to the core. It drives the host bus only when it is delivering a word. The bus pad itself sits outside, steered by an output-enable.

Top module: `rt_cmd_tracker`

## Requirements
- R1: On the clock edge where `cmdValid` is high, the command word {address[15:11], direction[10], subaddress[9:5], field[4:0]} is captured. From the next cycle `latBcast` is 1 exactly when the address is 31, `latTx` equals bit 10 (1 = transmit), and `latSubaddr` equals bits 9:5. These outputs hold until the next `cmdValid`. After reset every output is 0.
- R2: A subaddress of 0 or 31 marks a mode-code command. `wcOut` then shows field bits 4:0 and does not change until the next command, whatever data words or message-end pulses arrive.
- R3: In direct receive mode (burst flag captured as 0, or a mode-code command), a word sampled with `rxWordValid` appears on `hostDataOut` in the following cycle. In that cycle `hostDataOe` and `hostStrobe` are both 1, and in a data message `wcOut` shows the index of that word.
- R4: In data messages the index starts at 0 on each new command and advances by one per transferred word. It stops at field minus one, and a field of 0 means 32 words, so the index stops at 31.
- R5: In burst receive mode (burst flag captured as 1 with the command) sampled words are stored and not driven, and `wcOut` advances on the edge that stores each word.
- R6: A `msgEnd` pulse in burst receive mode with stored words starts a drain. `wcOut` restarts at 0. Each stored word, oldest first, is driven on `hostDataOut` with `hostDataOe` high for exactly 3 cycles, with `hostStrobe` high in the third. `wcOut` shows the word's index throughout.
- R7: `drainDone` rises on the edge that ends the drain transfer whose count equals the message word count. It is cleared by a new command or a new drain.
- R8: In transmit data messages a `txReadReq` samples `hostDataIn`. The following cycle shows that value on `txWordOut` with `txWordValid` high, and `wcOut` advances one cycle later.
- R9: `hostDataOe` is high only during a direct delivery cycle or a drain. During a transmit message or a burst fill it stays 0.
- R10: A command arriving during a drain stops the drain and discards the stored words. A later `msgEnd` with nothing newly stored does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| burstMode | input | 1 | Receive delivery mode, captured with each command (1 = store then drain) |
| cmdValid | input | 1 | One-cycle strobe for a new command word |
| cmdWord | input | 16 | Command word from the protocol core |
| rxWordValid | input | 1 | One-cycle strobe for a received data word |
| rxWord | input | 16 | Received data word |
| msgEnd | input | 1 | One-cycle end-of-message pulse |
| txReadReq | input | 1 | Core requests the next transmit word from the host |
| hostDataIn | input | 16 | Value read from the host bus pad |
| hostDataOut | output | 16 | Value driven toward the host bus pad |
| hostDataOe | output | 1 | Pad output enable; 0 leaves the bus high impedance |
| hostStrobe | output | 1 | Marks the cycle in which a word is handed to the host |
| txWordValid | output | 1 | Transmit word available to the core |
| txWordOut | output | 16 | Transmit word sampled from the host |
| latBcast | output | 1 | Captured broadcast flag |
| latTx | output | 1 | Captured direction flag (1 = transmit) |
| latSubaddr | output | 5 | Captured subaddress |
| wcOut | output | 5 | Running word index, or the mode code in mode-code messages |
| drainDone | output | 1 | Burst drain has delivered the full word count |

## Verification
The hardest situation to reach is a new command landing in the middle of a paced drain. The FIFO must then be partly emptied, the phase counter must sit between word boundaries, and the next burst message must start with no leftover words. The bench fills the FIFO with five words, fires the message end, and counts drain cycles at falling edges so that the new command lands in the second phase of the first word. It then opens an empty burst message and a one-word burst message, confirming that the bus stays released and that only the fresh word is delivered. Saturation at 32 words is reached by streaming 33 direct words under a zero field.

// File: rtl/rtcmd_pkg.sv
package rtcmd_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } drainState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic latchCmd;    // capture command fields, clear counters and FIFO
    logic passRx;      // deliver received word to host directly
    logic pushFifo;    // store received word
    logic popFifo;     // retire the word at the FIFO head
    logic capTx;       // sample host bus for the core
    logic cntClr;      // restart the word index
    logic cntInc;      // advance the word index (saturating)
    logic drainStart;  // begin paced delivery
    logic draining;    // drain in progress, FIFO head owns the bus
    logic xferLast;    // final cycle of a paced transfer
  } ctrlStrobe_t;

endpackage

// File: rtl/rtcmd_fifo.sv
module rtcmd_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              lastOne
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush;
  logic              doPop;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  assign doPush  = push && (count != CNT_FULL);
  assign doPop   = pop && (count != '0);
  assign empty   = (count == '0);
  assign lastOne = (count == CNT_ONE);
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= stepPtr(wrPtr);
      if (doPop)  rdPtr <= stepPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rtcmd_ctrl.sv
module rtcmd_ctrl
  import rtcmd_pkg::*;
#(
  parameter int XFER_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        rxWordValid,
  input  logic        msgEnd,
  input  logic        txReadReq,
  input  logic        isMode,
  input  logic        isTx,
  input  logic        isBurst,
  input  logic        fifoEmpty,
  input  logic        fifoLastOne,
  output ctrlStrobe_t strb
);

  localparam int PH_W = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(XFER_CYCLES - 1);

  drainState_t     state;
  logic [PH_W-1:0] phase;
  logic            pendInc;
  logic            idle;
  logic            directOk;
  logic            burstOk;

  assign idle     = (state == ST_IDLE);
  assign directOk = !isTx && (isMode || !isBurst);
  assign burstOk  = !isTx && !isMode && isBurst;

  always_comb begin
    strb            = '0;
    strb.latchCmd   = cmdValid;
    strb.draining   = (state == ST_DRAIN);
    strb.xferLast   = (state == ST_DRAIN) && (phase == PH_LAST);
    if (!cmdValid) begin
      strb.passRx     = rxWordValid && directOk && idle;
      strb.pushFifo   = rxWordValid && burstOk && idle;
      strb.capTx      = txReadReq && isTx;
      strb.drainStart = msgEnd && burstOk && idle && !fifoEmpty;
      strb.popFifo    = (state == ST_DRAIN) && (phase == PH_LAST);
      strb.cntClr     = msgEnd && burstOk && idle && !fifoEmpty;
      strb.cntInc     = pendInc
                     || (rxWordValid && burstOk && idle)
                     || ((state == ST_DRAIN) && (phase == PH_LAST));
    end
  end

  // direct and transmit transfers advance the index after the hand-over cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendInc <= 1'b0;
    end else begin
      pendInc <= !cmdValid && !isMode
              && ((rxWordValid && directOk && idle) || (txReadReq && isTx));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else if (cmdValid) begin
      state <= ST_IDLE;
      phase <= '0;
    end else if (idle) begin
      if (msgEnd && burstOk && !fifoEmpty) begin
        state <= ST_DRAIN;
        phase <= '0;
      end
    end else if (phase == PH_LAST) begin
      phase <= '0;
      if (fifoLastOne) state <= ST_IDLE;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/rtcmd_datapath.sv
module rtcmd_datapath
  import rtcmd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 5,
  parameter int SA_W       = 5,
  parameter int FIELD_W    = 5,
  parameter int FIFO_DEPTH = 32,
  localparam int CMD_W     = ADDR_W + 1 + SA_W + FIELD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic               burstMode,
  input  logic [CMD_W-1:0]   cmdWord,
  input  logic [DATA_W-1:0]  rxWord,
  input  logic [DATA_W-1:0]  hostDataIn,
  output logic               isMode,
  output logic               isTx,
  output logic               isBurst,
  output logic               fifoEmpty,
  output logic               fifoLastOne,
  output logic [FIELD_W-1:0] fieldLat,
  output logic [DATA_W-1:0]  hostDataOut,
  output logic               hostDataOe,
  output logic               hostStrobe,
  output logic               txWordValid,
  output logic [DATA_W-1:0]  txWordOut,
  output logic               latBcast,
  output logic [SA_W-1:0]    latSubaddr,
  output logic [FIELD_W-1:0] wcOut
);

  localparam int TX_POS = FIELD_W + SA_W;
  localparam int CNT_W  = FIELD_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAXMSG = CNT_W'(1) << FIELD_W;

  logic [ADDR_W-1:0]  addrNew;
  logic [SA_W-1:0]    saNew;
  logic [FIELD_W-1:0] fieldNew;
  logic               txNew;

  logic               bcastQ;
  logic               txQ;
  logic               burstQ;
  logic [SA_W-1:0]    saQ;
  logic [FIELD_W-1:0] fieldQ;
  logic [FIELD_W-1:0] cwc;
  logic [FIELD_W-1:0] lastIdx;
  logic [CNT_W-1:0]   totalWords;
  logic [CNT_W-1:0]   drainCnt;
  logic               doneQ;
  logic [DATA_W-1:0]  outWordQ;
  logic               passQ;
  logic [DATA_W-1:0]  txWordQ;
  logic               txValidQ;
  logic [DATA_W-1:0]  fifoHead;

  assign addrNew  = cmdWord[CMD_W-1 -: ADDR_W];
  assign txNew    = cmdWord[TX_POS];
  assign saNew    = cmdWord[FIELD_W +: SA_W];
  assign fieldNew = cmdWord[FIELD_W-1:0];

  // command field capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcastQ <= 1'b0;
      txQ    <= 1'b0;
      burstQ <= 1'b0;
      saQ    <= '0;
      fieldQ <= '0;
    end else if (strb.latchCmd) begin
      bcastQ <= &addrNew;
      txQ    <= txNew;
      burstQ <= burstMode;
      saQ    <= saNew;
      fieldQ <= fieldNew;
    end
  end

  assign isMode     = (saQ == '0) || (&saQ);
  assign isTx       = txQ;
  assign isBurst    = burstQ;
  assign fieldLat   = fieldQ;
  assign lastIdx    = fieldQ - 1'b1;
  assign totalWords = (fieldQ == '0) ? CNT_MAXMSG : {1'b0, fieldQ};

  // running word index, saturating at the last word of the message
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cwc <= '0;
    end else if (strb.latchCmd || strb.cntClr) begin
      cwc <= '0;
    end else if (strb.cntInc && (cwc != lastIdx)) begin
      cwc <= cwc + 1'b1;
    end
  end

  // drain progress and completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drainCnt <= '0;
      doneQ    <= 1'b0;
    end else if (strb.latchCmd || strb.drainStart) begin
      drainCnt <= '0;
      doneQ    <= 1'b0;
    end else if (strb.popFifo) begin
      drainCnt <= drainCnt + 1'b1;
      if ((drainCnt + 1'b1) == totalWords) doneQ <= 1'b1;
    end
  end

  // direct delivery and transmit capture registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWordQ <= '0;
      passQ    <= 1'b0;
      txWordQ  <= '0;
      txValidQ <= 1'b0;
    end else begin
      passQ    <= strb.passRx;
      txValidQ <= strb.capTx;
      if (strb.passRx) outWordQ <= rxWord;
      if (strb.capTx)  txWordQ  <= hostDataIn;
    end
  end

  rtcmd_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (strb.latchCmd),
    .push    (strb.pushFifo),
    .pop     (strb.popFifo),
    .wrData  (rxWord),
    .rdData  (fifoHead),
    .empty   (fifoEmpty),
    .lastOne (fifoLastOne)
  );

  assign hostDataOut = strb.draining ? fifoHead : outWordQ;
  assign hostDataOe  = strb.draining || passQ;
  assign hostStrobe  = strb.xferLast || passQ;
  assign txWordValid = txValidQ;
  assign txWordOut   = txWordQ;
  assign latBcast    = bcastQ;
  assign latSubaddr  = saQ;
  assign wcOut       = isMode ? fieldQ : cwc;

  // drainDone is taken from the top through fieldLat-independent path
  logic unusedDone;
  assign unusedDone = doneQ;

endmodule

// File: rtl/rt_cmd_tracker.sv
module rt_cmd_tracker
  import rtcmd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int SA_W        = 5,
  parameter int FIELD_W     = 5,
  parameter int FIFO_DEPTH  = 32,
  parameter int XFER_CYCLES = 3,
  localparam int CMD_W      = ADDR_W + 1 + SA_W + FIELD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               burstMode,
  input  logic               cmdValid,
  input  logic [CMD_W-1:0]   cmdWord,
  input  logic               rxWordValid,
  input  logic [DATA_W-1:0]  rxWord,
  input  logic               msgEnd,
  input  logic               txReadReq,
  input  logic [DATA_W-1:0]  hostDataIn,
  output logic [DATA_W-1:0]  hostDataOut,
  output logic               hostDataOe,
  output logic               hostStrobe,
  output logic               txWordValid,
  output logic [DATA_W-1:0]  txWordOut,
  output logic               latBcast,
  output logic               latTx,
  output logic [SA_W-1:0]    latSubaddr,
  output logic [FIELD_W-1:0] wcOut,
  output logic               drainDone
);

  ctrlStrobe_t        strb;
  logic               isMode;
  logic               isTx;
  logic               isBurst;
  logic               fifoEmpty;
  logic               fifoLastOne;
  logic [FIELD_W-1:0] fieldLat;

  rtcmd_ctrl #(
    .XFER_CYCLES (XFER_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .rxWordValid (rxWordValid),
    .msgEnd      (msgEnd),
    .txReadReq   (txReadReq),
    .isMode      (isMode),
    .isTx        (isTx),
    .isBurst     (isBurst),
    .fifoEmpty   (fifoEmpty),
    .fifoLastOne (fifoLastOne),
    .strb        (strb)
  );

  rtcmd_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .SA_W       (SA_W),
    .FIELD_W    (FIELD_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .burstMode   (burstMode),
    .cmdWord     (cmdWord),
    .rxWord      (rxWord),
    .hostDataIn  (hostDataIn),
    .isMode      (isMode),
    .isTx        (isTx),
    .isBurst     (isBurst),
    .fifoEmpty   (fifoEmpty),
    .fifoLastOne (fifoLastOne),
    .fieldLat    (fieldLat),
    .hostDataOut (hostDataOut),
    .hostDataOe  (hostDataOe),
    .hostStrobe  (hostStrobe),
    .txWordValid (txWordValid),
    .txWordOut   (txWordOut),
    .latBcast    (latBcast),
    .latSubaddr  (latSubaddr),
    .wcOut       (wcOut)
  );

  assign latTx     = isTx;
  assign drainDone = u_dp.doneQ;

endmodule

// File: rtl/rtcmd_chk.sv
module rtcmd_chk #(
  parameter int SA_W    = 5,
  parameter int FIELD_W = 5,
  parameter int CMD_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic [CMD_W-1:0]   cmdWord,
  input logic               txReadReq,
  input logic               hostDataOe,
  input logic               hostStrobe,
  input logic               txWordValid,
  input logic               latTx,
  input logic [SA_W-1:0]    latSubaddr,
  input logic [FIELD_W-1:0] wcOut,
  input logic [FIELD_W-1:0] fieldLat,
  input logic               drainDone
);

  logic modeNow;
  assign modeNow = (latSubaddr == '0) || (&latSubaddr);

  AST_CMD_SUBADDR: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> latSubaddr == $past(cmdWord[FIELD_W +: SA_W])); // R1

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && modeNow) |=> $stable(wcOut)); // R2

  AST_STROBE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    hostStrobe |-> hostDataOe); // R3

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    !modeNow |-> (wcOut <= FIELD_W'(fieldLat - 1'b1))); // R4

  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drainDone) |-> $past(hostStrobe)); // R7

  AST_TXV_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    txWordValid |-> ($past(txReadReq) && $past(latTx))); // R8

  AST_TX_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    latTx |-> !hostDataOe); // R9

endmodule

bind rt_cmd_tracker rtcmd_chk u_chk (.*);

// File: tb/sim_rt_cmd_tracker.sv
module sim_rt_cmd_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 6;

  // command {addr, dir, subaddr, field} and expected {bcast, tx, subaddr, wcOut}
  localparam logic [15:0] VEC_CMD [NVEC] = '{
    {5'd3,  1'b0, 5'd4,  5'd7},
    {5'd31, 1'b1, 5'd9,  5'd0},
    {5'd5,  1'b0, 5'd0,  5'd17},
    {5'd31, 1'b1, 5'd31, 5'd2},
    {5'd10, 1'b1, 5'd30, 5'd5},
    {5'd0,  1'b0, 5'd1,  5'd31}
  };
  localparam logic [11:0] VEC_EXP [NVEC] = '{
    {1'b0, 1'b0, 5'd4,  5'd0},
    {1'b1, 1'b1, 5'd9,  5'd0},
    {1'b0, 1'b0, 5'd0,  5'd17},
    {1'b1, 1'b1, 5'd31, 5'd2},
    {1'b0, 1'b1, 5'd30, 5'd0},
    {1'b0, 1'b0, 5'd1,  5'd0}
  };
  localparam logic [15:0] BW [4] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        burstMode = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic        rxWordValid = 1'b0;
  logic [15:0] rxWord = '0;
  logic        msgEnd = 1'b0;
  logic        txReadReq = 1'b0;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut;
  logic        hostDataOe;
  logic        hostStrobe;
  logic        txWordValid;
  logic [15:0] txWordOut;
  logic        latBcast;
  logic        latTx;
  logic [4:0]  latSubaddr;
  logic [4:0]  wcOut;
  logic        drainDone;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  finished = 1'b0;

  rt_cmd_tracker u0 (
    .clk         (clk),
    .rstN        (rstN),
    .burstMode   (burstMode),
    .cmdValid    (cmdValid),
    .cmdWord     (cmdWord),
    .rxWordValid (rxWordValid),
    .rxWord      (rxWord),
    .msgEnd      (msgEnd),
    .txReadReq   (txReadReq),
    .hostDataIn  (hostDataIn),
    .hostDataOut (hostDataOut),
    .hostDataOe  (hostDataOe),
    .hostStrobe  (hostStrobe),
    .txWordValid (txWordValid),
    .txWordOut   (txWordOut),
    .latBcast    (latBcast),
    .latTx       (latTx),
    .latSubaddr  (latSubaddr),
    .wcOut       (wcOut),
    .drainDone   (drainDone)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic sendCmd(input logic [4:0] a, input logic t, input logic [4:0] s, input logic [4:0] f);
    cmdWord  = {a, t, s, f};
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic sendRx(input logic [15:0] v);
    rxWord      = v;
    rxWordValid = 1'b1;
    @(negedge clk);
    rxWordValid = 1'b0;
  endtask

  task automatic pulseEnd();
    msgEnd = 1'b1;
    @(negedge clk);
    msgEnd = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset oe", 32'(hostDataOe), 0);
    check("R1 reset strobe", 32'(hostStrobe), 0);
    check("R1 reset fields", 32'({latBcast, latTx, latSubaddr, wcOut}), 0);
    check("R1 reset done", 32'(drainDone), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2: command vectors
    for (int i = 0; i < NVEC; i++) begin
      sendCmd(VEC_CMD[i][15:11], VEC_CMD[i][10], VEC_CMD[i][9:5], VEC_CMD[i][4:0]);
      check($sformatf("R1 vector %0d", i), 32'({latBcast, latTx, latSubaddr, wcOut}), 32'(VEC_EXP[i]));
    end

    // R3 R4: direct receive, field 3, one extra word
    burstMode = 1'b0;
    sendCmd(5'd1, 1'b0, 5'd2, 5'd3);
    check("R4 index starts 0", 32'(wcOut), 0);
    for (int k = 0; k < 4; k++) begin
      sendRx(16'hA000 + 16'(k));
      check("R3 strobe", 32'(hostStrobe), 1);
      check("R3 oe", 32'(hostDataOe), 1);
      check("R3 data", 32'(hostDataOut), 32'(16'hA000 + 16'(k)));
      check("R3 index during", 32'(wcOut), 32'((k > 2) ? 2 : k));
      @(negedge clk);
      check("R9 oe released", 32'(hostDataOe), 0);
      check("R4 index after", 32'(wcOut), 32'((k + 1 > 2) ? 2 : k + 1));
    end

    // R4: zero field means 32 words
    sendCmd(5'd2, 1'b0, 5'd6, 5'd0);
    for (int k = 0; k < 33; k++) begin
      sendRx(16'(k));
      @(negedge clk);
      check("R4 32-word index", 32'(wcOut), 32'((k + 1 > 31) ? 31 : k + 1));
    end

    // R5 R6 R7: burst receive then paced drain
    burstMode = 1'b1;
    sendCmd(5'd4, 1'b0, 5'd3, 5'd4);
    for (int k = 0; k < 4; k++) begin
      sendRx(BW[k]);
      check("R5 no drive in fill", 32'(hostDataOe), 0);
      check("R5 fill index", 32'(wcOut), 32'((k + 1 > 3) ? 3 : k + 1));
    end
    check("R7 done low before drain", 32'(drainDone), 0);
    pulseEnd();
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 3; p++) begin
        check("R6 drain oe", 32'(hostDataOe), 1);
        check("R6 drain data", 32'(hostDataOut), 32'(BW[w]));
        check("R6 drain index", 32'(wcOut), 32'(w));
        check("R6 drain strobe", 32'(hostStrobe), 32'(p == 2));
        @(negedge clk);
      end
    end
    check("R6 bus released", 32'(hostDataOe), 0);
    check("R7 done", 32'(drainDone), 1);
    check("R4 drain index held", 32'(wcOut), 3);

    // R10: abort mid drain, then empty and one-word bursts
    sendCmd(5'd1, 1'b0, 5'd7, 5'd0);
    check("R7 done cleared", 32'(drainDone), 0);
    for (int k = 0; k < 5; k++) sendRx(16'hC000 + 16'(k));
    check("R5 five stored", 32'(wcOut), 5);
    pulseEnd();
    check("R6 first word", 32'(hostDataOut), 32'h0000C000);
    @(negedge clk);
    burstMode = 1'b0;
    sendCmd(5'd1, 1'b0, 5'd7, 5'd3);
    check("R10 abort oe", 32'(hostDataOe), 0);
    check("R10 abort strobe", 32'(hostStrobe), 0);
    check("R10 abort index", 32'(wcOut), 0);
    burstMode = 1'b1;
    sendCmd(5'd1, 1'b0, 5'd8, 5'd1);
    pulseEnd();
    check("R10 empty no drive", 32'(hostDataOe), 0);
    @(negedge clk);
    check("R10 empty stays idle", 32'(hostDataOe), 0);
    sendRx(16'hBEEF);
    check("R4 single-word index", 32'(wcOut), 0);
    pulseEnd();
    check("R10 only fresh word", 32'(hostDataOut), 32'h0000BEEF);
    repeat (3) @(negedge clk);
    check("R10 drain finished", 32'(hostDataOe), 0);
    check("R7 single done", 32'(drainDone), 1);

    // R8 R9: transmit data message
    sendCmd(5'd6, 1'b1, 5'd5, 5'd2);
    hostDataIn = 16'hA5A5;
    txReadReq  = 1'b1;
    @(negedge clk);
    txReadReq  = 1'b0;
    check("R8 tx valid", 32'(txWordValid), 1);
    check("R8 tx word", 32'(txWordOut), 32'h0000A5A5);
    check("R9 tx no drive", 32'(hostDataOe), 0);
    check("R8 index during", 32'(wcOut), 0);
    @(negedge clk);
    check("R8 valid one cycle", 32'(txWordValid), 0);
    check("R8 index after", 32'(wcOut), 1);
    hostDataIn = 16'h5A5A;
    txReadReq  = 1'b1;
    @(negedge clk);
    txReadReq  = 1'b0;
    check("R8 second word", 32'(txWordOut), 32'h00005A5A);
    @(negedge clk);
    check("R4 tx index held", 32'(wcOut), 1);

    // R2: mode code holds through words and message end
    burstMode = 1'b1;
    sendCmd(5'd7, 1'b0, 5'd31, 5'd9);
    check("R2 mode field", 32'(wcOut), 9);
    sendRx(16'h0F0F);
    check("R2 mode word direct", 32'(hostDataOut), 32'h00000F0F);
    check("R2 mode strobe", 32'(hostStrobe), 1);
    check("R2 mode field during", 32'(wcOut), 9);
    @(negedge clk);
    pulseEnd();
    check("R2 no drain on mode", 32'(hostDataOe), 0);
    check("R2 mode field after", 32'(wcOut), 9);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule